// File: doc/BRIEF.md
# Two-Channel Command Latch Bank with Holding Buffer

This block turns 16-bit command words into the digital state of a two-channel converter. A word arrives with a one-cycle valid strobe. Two address bits in the word pick where its 10-bit data field goes: channel B together with a holding buffer, the holding buffer alone, channel A, or a small control register. A write to channel A also moves the holding buffer into channel B, so both channels can take new codes on the same clock edge.

Every accepted word also carries a speed-mode bit and a power-down bit, and both are applied whatever the address. While power-down is set, the per-channel output enables go low. The channel codes are kept, so leaving power-down brings back the previous codes. A synchronous reset clears all stored state. Serial capture of the word and the analog conversion sit outside this block. All outputs update one clock after the strobed word.

Top module: `dual_latch_ctrl`

## Requirements
- R1: A synchronous reset clears both channel codes, the holding buffer, the speed flag, the power-down flag and the reference select to zero, so both enables are high.
- R2: Address 00 (bit 15 = 0, bit 12 = 0) writes data bits 11..2 into channel B and the holding buffer, and leaves channel A unchanged.
- R3: Address 01 (bit 15 = 0, bit 12 = 1) writes the data into the holding buffer only, and leaves both channel codes unchanged.
- R4: Address 10 (bit 15 = 1, bit 12 = 0) writes the data into channel A and, on the same clock edge, copies the holding buffer into channel B. The buffer itself is unchanged.
- R5: Address 11 writes bits 1..0 into the reference select (00 external, 01 low internal level, 10 high internal level, 11 external) and changes no channel code. Writes to other addresses leave the reference select unchanged.
- R6: Every accepted word loads bit 14 into the speed flag (1 fast, 0 slow) and bit 13 into the power-down flag (1 powered down), whatever its address.
- R7: Entering and then leaving power-down keeps both channel codes, so the previous codes return.
- R8: While the power-down flag is set, both channel enables are low. Otherwise both are high.
- R9: When the valid strobe is low, no output changes, whatever the word input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 16 | Command word |
| cmd_valid | input | 1 | Strobe: accept cmd_word this cycle |
| chan_a_code | output | 10 | Channel A code |
| chan_b_code | output | 10 | Channel B code |
| chan_a_en | output | 1 | Channel A output enable |
| chan_b_en | output | 1 | Channel B output enable |
| fast_mode | output | 1 | Speed flag, 1 = fast settling |
| pwr_down | output | 1 | Power-down flag |
| ref_sel | output | 2 | Reference select |

## Verification
The holding buffer has no port, so a wrong value in it stays hidden until the next address-10 write copies it into channel B. The stimulus therefore pairs each buffer-only write with a later channel A write, and the bench checks channel B on the first cycle after that write. Wrong mode or control state shows on the flag outputs one cycle after the word. A power-down or strobe fault shows as channel codes that differ from the model when power-down is released, or after an idle cycle.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_HI  = 15;
  localparam int ADDR_LO  = 12;
  localparam int SPEED_B  = 14;
  localparam int PDOWN_B  = 13;
  localparam int DATA_LSB = 2;
  localparam int REF_W    = 2;

  typedef enum logic [1:0] {
    DST_B_AND_HOLD = 2'b00,
    DST_HOLD_ONLY  = 2'b01,
    DST_A_SYNC_B   = 2'b10,
    DST_CONTROL    = 2'b11
  } dest_e;
endpackage

// File: rtl/dlc_decode.sv
module dlc_decode
  import dlc_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic [WORD_W-1:0] word,
  input  logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              wr_a,
  output logic              wr_b_direct,
  output logic              wr_b_from_hold,
  output logic              wr_hold,
  output logic              wr_ctrl,
  output logic              mode_we,
  output logic              speed_bit,
  output logic              pdown_bit,
  output logic [REF_W-1:0]  ref_bits
);
  dest_e dest;

  always_comb begin
    dest           = dest_e'({word[ADDR_HI], word[ADDR_LO]});
    data           = word[DATA_LSB +: DATA_W];
    speed_bit      = word[SPEED_B];
    pdown_bit      = word[PDOWN_B];
    ref_bits       = word[REF_W-1:0];
    mode_we        = valid;
    wr_a           = 1'b0;
    wr_b_direct    = 1'b0;
    wr_b_from_hold = 1'b0;
    wr_hold        = 1'b0;
    wr_ctrl        = 1'b0;
    if (valid) begin
      unique case (dest)
        DST_B_AND_HOLD: begin
          wr_b_direct = 1'b1;
          wr_hold     = 1'b1;
        end
        DST_HOLD_ONLY:  wr_hold = 1'b1;
        DST_A_SYNC_B: begin
          wr_a           = 1'b1;
          wr_b_from_hold = 1'b1;
        end
        DST_CONTROL:    wr_ctrl = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dlc_latches.sv
module dlc_latches #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data,
  input  logic              wr_a,
  input  logic              wr_b_direct,
  input  logic              wr_b_from_hold,
  input  logic              wr_hold,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_a <= '0;
      code_b <= '0;
      hold_q <= '0;
    end else begin
      if (wr_a)           code_a <= data;
      if (wr_b_direct)    code_b <= data;
      else if (wr_b_from_hold) code_b <= hold_q;
      if (wr_hold)        hold_q <= data;
    end
  end
endmodule

// File: rtl/dlc_mode_regs.sv
module dlc_mode_regs
  import dlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic             speed_bit,
  input  logic             pdown_bit,
  input  logic             wr_ctrl,
  input  logic [REF_W-1:0] ref_bits,
  output logic             fast_q,
  output logic             pdown_q,
  output logic [REF_W-1:0] ref_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q  <= 1'b0;
      pdown_q <= 1'b0;
      ref_q   <= '0;
    end else begin
      if (mode_we) begin
        fast_q  <= speed_bit;
        pdown_q <= pdown_bit;
      end
      if (wr_ctrl) ref_q <= ref_bits;
    end
  end
endmodule

// File: rtl/dual_latch_ctrl.sv
module dual_latch_ctrl
  import dlc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int N_CH   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cmd_word,
  input  logic              cmd_valid,
  output logic [DATA_W-1:0] chan_a_code,
  output logic [DATA_W-1:0] chan_b_code,
  output logic              chan_a_en,
  output logic              chan_b_en,
  output logic              fast_mode,
  output logic              pwr_down,
  output logic [1:0]        ref_sel
);
  logic [DATA_W-1:0] data;
  logic wr_a, wr_b_direct, wr_b_from_hold, wr_hold, wr_ctrl;
  logic mode_we, speed_bit, pdown_bit;
  logic [REF_W-1:0] ref_bits;
  logic [N_CH-1:0] en_vec;

  dlc_decode #(.DATA_W(DATA_W)) u_dec (
    .word(cmd_word), .valid(cmd_valid), .data(data),
    .wr_a(wr_a), .wr_b_direct(wr_b_direct), .wr_b_from_hold(wr_b_from_hold),
    .wr_hold(wr_hold), .wr_ctrl(wr_ctrl), .mode_we(mode_we),
    .speed_bit(speed_bit), .pdown_bit(pdown_bit), .ref_bits(ref_bits)
  );

  dlc_latches #(.DATA_W(DATA_W)) u_lat (
    .clk(clk), .rst(rst), .data(data), .wr_a(wr_a),
    .wr_b_direct(wr_b_direct), .wr_b_from_hold(wr_b_from_hold),
    .wr_hold(wr_hold), .code_a(chan_a_code), .code_b(chan_b_code)
  );

  dlc_mode_regs u_mode (
    .clk(clk), .rst(rst), .mode_we(mode_we), .speed_bit(speed_bit),
    .pdown_bit(pdown_bit), .wr_ctrl(wr_ctrl), .ref_bits(ref_bits),
    .fast_q(fast_mode), .pdown_q(pwr_down), .ref_q(ref_sel)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_en
    assign en_vec[c] = ~pwr_down;
  end
  assign chan_a_en = en_vec[0];
  assign chan_b_en = en_vec[N_CH-1];
endmodule

// File: rtl/dual_latch_ctrl_chk.sv
module dual_latch_ctrl_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cmd_word,
  input logic              cmd_valid,
  input logic [DATA_W-1:0] chan_a_code,
  input logic [DATA_W-1:0] chan_b_code,
  input logic              chan_a_en,
  input logic              chan_b_en,
  input logic              fast_mode,
  input logic              pwr_down,
  input logic [1:0]        ref_sel
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (chan_a_code == '0 && chan_b_code == '0 && !pwr_down && !fast_mode && ref_sel == 2'b00));

  p_b_and_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_word[15] && !cmd_word[12]) |=>
      (chan_b_code == $past(cmd_word[11:2]) && $stable(chan_a_code)));

  p_hold_only_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_word[15] && cmd_word[12]) |=>
      ($stable(chan_a_code) && $stable(chan_b_code)));

  p_a_write_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[15] && !cmd_word[12]) |=> chan_a_code == $past(cmd_word[11:2]));

  p_ref_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !(cmd_word[15] && cmd_word[12])) |=> $stable(ref_sel));

  p_mode_bits_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (pwr_down == $past(cmd_word[13]) && fast_mode == $past(cmd_word[14])));

  p_enables_r8: assert property (@(posedge clk) disable iff (rst)
    (chan_a_en == chan_b_en) && (chan_a_en != pwr_down));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(chan_a_code) && $stable(chan_b_code) && $stable(ref_sel)
                    && $stable(pwr_down) && $stable(fast_mode)));
endmodule

bind dual_latch_ctrl dual_latch_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dual_latch_ctrl_test.sv
module dual_latch_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cmd_word = '0;
  logic cmd_valid = 1'b0;
  logic [9:0] chan_a_code, chan_b_code;
  logic chan_a_en, chan_b_en, fast_mode, pwr_down;
  logic [1:0] ref_sel;

  int errors = 0;
  int checks = 0;
  int m_a, m_b, m_h, m_fast, m_pd, m_ref;

  always #10 clk = ~clk;

  dual_latch_ctrl uut (
    .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .chan_a_code(chan_a_code), .chan_b_code(chan_b_code),
    .chan_a_en(chan_a_en), .chan_b_en(chan_b_en),
    .fast_mode(fast_mode), .pwr_down(pwr_down), .ref_sel(ref_sel)
  );

  function automatic logic [15:0] mk(input int adr, input int sp, input int pd,
                                     input int data, input int low);
    return {adr[1], sp[0], pd[0], adr[0], data[9:0], low[1:0]};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "chan_a_code", int'(chan_a_code), m_a);
    chk(req, "chan_b_code", int'(chan_b_code), m_b);
    chk(req, "fast_mode",   int'(fast_mode),   m_fast);
    chk(req, "pwr_down",    int'(pwr_down),    m_pd);
    chk(req, "ref_sel",     int'(ref_sel),     m_ref);
    chk(req, "chan_a_en",   int'(chan_a_en),   m_pd ? 0 : 1);
    chk(req, "chan_b_en",   int'(chan_b_en),   m_pd ? 0 : 1);
  endtask

  task automatic model_reset();
    m_a = 0; m_b = 0; m_h = 0; m_fast = 0; m_pd = 0; m_ref = 0;
  endtask

  // drive at negedge, let one posedge pass, compare at next negedge
  task automatic step(input logic [15:0] w, input logic v, input string req);
    int adr, d;
    cmd_word  = w;
    cmd_valid = v;
    @(posedge clk);
    if (v) begin
      adr = {w[15], w[12]};
      d   = int'(w[11:2]);
      m_fast = w[14];
      m_pd   = w[13];
      case (adr)
        0: begin m_b = d; m_h = d; end
        1: m_h = d;
        2: begin m_a = d; m_b = m_h; end
        default: m_ref = int'(w[1:0]);
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check_all(req);
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    cmd_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    check_all(req);
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset("R1");
    // R2: B and holding buffer
    step(mk(0, 1, 0, 10'h3FF, 3), 1'b1, "R2");
    // R4: A write pulls buffer into B
    step(mk(2, 1, 0, 10'h200, 0), 1'b1, "R4");
    // R3: buffer only, channels stay
    step(mk(1, 1, 0, 10'h0AA, 0), 1'b1, "R3");
    step(mk(1, 0, 0, 10'h155, 1), 1'b1, "R3");
    // R4: both channels change on one edge, buffer kept
    step(mk(2, 0, 0, 10'h111, 2), 1'b1, "R4");
    step(mk(2, 0, 0, 10'h001, 0), 1'b1, "R4");
    // R9: strobe low ignored
    step(mk(0, 1, 1, 10'h2AB, 0), 1'b0, "R9");
    step(mk(3, 1, 1, 10'h0F0, 2), 1'b0, "R9");
    // R5: control register, all four select codes, junk data field
    step(mk(3, 1, 0, 10'h3C3, 1), 1'b1, "R5");
    step(mk(3, 0, 0, 10'h2A2, 2), 1'b1, "R5");
    step(mk(3, 1, 0, 10'h111, 3), 1'b1, "R5");
    step(mk(0, 1, 0, 10'h0C0, 1), 1'b1, "R5");
    step(mk(3, 0, 0, 10'h3FF, 0), 1'b1, "R5");
    step(mk(3, 0, 0, 10'h000, 2), 1'b1, "R5");
    // R6: mode bits from data writes of every address
    step(mk(1, 1, 0, 10'h321, 0), 1'b1, "R6");
    step(mk(0, 0, 0, 10'h045, 0), 1'b1, "R6");
    step(mk(2, 1, 0, 10'h1EE, 0), 1'b1, "R6");
    // R8/R7: power-down via control word, then via data write, then release
    step(mk(3, 1, 1, 10'h000, 2), 1'b1, "R8");
    step(mk(1, 1, 1, 10'h2F0, 0), 1'b1, "R8");
    step(mk(3, 1, 0, 10'h000, 2), 1'b1, "R7");
    step(mk(2, 0, 1, 10'h3A5, 0), 1'b1, "R8");
    step(mk(3, 0, 0, 10'h000, 1), 1'b1, "R7");
    step(mk(2, 0, 0, 10'h0AB, 0), 1'b1, "R4");
    // R1: reset mid-run
    do_reset("R1");
    step(mk(2, 0, 0, 10'h155, 0), 1'b1, "R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule